// File: doc/BRIEF.md
# Interrupt Pin Service and Remote-IRR Tracker

This block sits in front of the delivery stage of a redirecting interrupt router. For each input pin it samples the raw line level, applies that pin's polarity setting, and keeps a pending-request bit. Using the pin's trigger mode, mask bit and remote-IRR flag, it decides which pins want delivery, and it offers the lowest-numbered one to the delivery stage as a request that carries the pin index. It does not decode destinations. The delivery stage reports through a separate input whether any target accepted the interrupt.

Level-triggered pins use a handshake. After an accepted delivery, the pin's remote-IRR flag is set, and the pin cannot request again until an end-of-interrupt (EOI) message arrives whose vector matches the vector field of that pin's entry. The EOI clears remote IRR on every matching level-triggered entry. Any of those entries that is still active and unmasked then requests again. Edge-triggered pins need no such handshake: a rising effective edge makes the pin pending, and servicing the pin clears that pending bit.

The request side is a valid/ready stream. A transfer takes place in a cycle where `req_valid` and `req_ready` are both high, and `req_accepted` is sampled in that same cycle. While `req_ready` is low, no state changes because of the request. The offered index reflects live eligibility, so `req_pin` can change only when a lower-numbered pin becomes eligible or the offered pin stops being eligible, for example because it was masked. The consumer must therefore act on `req_pin` only in the cycle in which it asserts `req_ready`.

Top module: `irq_pin_router`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `req_valid` is 0, and no pin is pending and no remote-IRR flag is set.
- R2: The effective level of pin i is `pin_level[i] ^ polarity[i]`. With polarity 1, a low line is treated as active.
- R3: A level-triggered pin (`trig_level[i]`=1) has its pending bit equal to the effective level registered on the previous clock edge. It requests while that bit is 1, it is unmasked, and its remote IRR is 0.
- R4: A transfer for a level-triggered pin with `req_accepted`=1 sets its remote IRR, which blocks further requests from that pin. With `req_accepted`=0, remote IRR stays clear and the pin keeps requesting.
- R5: An edge-triggered pin (`trig_level[i]`=0) becomes pending on a 0-to-1 change of its effective level. The pending bit is cleared by a transfer for that pin, or when the effective level goes to 0. A line held high does not request again.
- R6: A masked pin never requests. An edge-triggered pin that is pending while masked loses its pending bit, so unmasking it later produces no request.
- R7: An EOI (`eoi_valid` high for one cycle) clears remote IRR on every level-triggered pin whose 8-bit vector field equals `eoi_vector`. A matching pin that is still active and unmasked then requests again. A non-matching EOI changes nothing. A transfer in the same cycle as a matching EOI leaves remote IRR set.
- R8: When several pins want service, `req_pin` is the lowest index among them, and one pin is transferred per cycle.
- R9: While `req_ready` is low, no pending or remote-IRR state changes because of the request, and an eligible pin stays offered.
- R10: Unmasking a level-triggered pin whose line is active and whose remote IRR is clear produces a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_level | input | NPINS | Raw pin levels |
| polarity | input | NPINS | Per-pin polarity; 1 inverts the line |
| trig_level | input | NPINS | Per-pin trigger mode; 1 = level, 0 = edge |
| mask | input | NPINS | Per-pin mask; 1 = masked |
| vec_flat | input | NPINS*VEC_W | Per-pin vector fields; pin i occupies bits [i*VEC_W +: VEC_W] |
| eoi_valid | input | 1 | EOI strobe |
| eoi_vector | input | VEC_W | Vector carried by the EOI |
| req_valid | output | 1 | A pin is offered for delivery |
| req_ready | input | 1 | Delivery stage takes the offered pin |
| req_accepted | input | 1 | At least one target accepted; sampled when a transfer occurs |
| req_pin | output | $clog2(NPINS) | Index of the offered pin |

## Verification
The hardest situation to reach is the interaction on a level-triggered pin between its remote-IRR flag and its line. The pin must be delivered and accepted, then see an EOI with the wrong vector, then one with the right vector while the line is still active, and finally an EOI after the line has dropped. The directed stimulus walks through this sequence one pin at a time. A long random phase follows that toggles lines, masks and trigger modes, throttles `req_ready`, and sends EOIs for two pins that share a vector. This makes same-cycle EOI-and-transfer collisions and multi-entry matches occur many times. A behavioural model in the bench predicts `req_valid` and `req_pin` on every cycle.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam logic TRIG_EDGE  = 1'b0;
  localparam logic TRIG_LEVEL = 1'b1;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/irq_pin_slot.sv
module irq_pin_slot
  import irq_router_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line,
  input  logic             pol,
  input  logic             trig,
  input  logic             msk,
  input  logic [VEC_W-1:0] vec,
  input  logic             eoi_valid,
  input  logic [VEC_W-1:0] eoi_vector,
  input  logic             served,
  input  logic             accepted,
  output logic             want
);
  logic eff, prev_q, pend_q, pend_d, rirr_q, rirr_d, rise, eoi_hit;

  assign eff     = line ^ pol;
  assign rise    = eff & ~prev_q;
  assign eoi_hit = eoi_valid && (vec == eoi_vector) && (trig == TRIG_LEVEL);

  always_comb begin
    if (trig == TRIG_LEVEL)       pend_d = eff;
    else if (rise)                pend_d = 1'b1;
    else if (!eff)                pend_d = 1'b0;
    else if (served || msk)       pend_d = 1'b0;
    else                          pend_d = pend_q;
  end

  always_comb begin
    if (served && accepted && trig == TRIG_LEVEL) rirr_d = 1'b1;
    else if (eoi_hit)                             rirr_d = 1'b0;
    else                                          rirr_d = rirr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      rirr_q <= 1'b0;
    end else begin
      prev_q <= eff;
      pend_q <= pend_d;
      rirr_q <= rirr_d;
    end
  end

  assign want = pend_q && !msk && ((trig == TRIG_EDGE) || !rirr_q);
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     want,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (want[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_pin_router.sv
module irq_pin_router
  import irq_router_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int VEC_W = 8,
  localparam int IDX_W = idx_width(NPINS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NPINS-1:0]       pin_level,
  input  logic [NPINS-1:0]       polarity,
  input  logic [NPINS-1:0]       trig_level,
  input  logic [NPINS-1:0]       mask,
  input  logic [NPINS*VEC_W-1:0] vec_flat,
  input  logic                   eoi_valid,
  input  logic [VEC_W-1:0]       eoi_vector,
  output logic                   req_valid,
  input  logic                   req_ready,
  input  logic                   req_accepted,
  output logic [IDX_W-1:0]       req_pin
);
  logic [NPINS-1:0] want;
  logic             xfer;

  assign xfer = req_valid && req_ready;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    irq_pin_slot #(.VEC_W(VEC_W)) u_slot (
      .clk        (clk),
      .rst        (rst),
      .line       (pin_level[g]),
      .pol        (polarity[g]),
      .trig       (trig_level[g]),
      .msk        (mask[g]),
      .vec        (vec_flat[g*VEC_W +: VEC_W]),
      .eoi_valid  (eoi_valid),
      .eoi_vector (eoi_vector),
      .served     (xfer && (req_pin == IDX_W'(g))),
      .accepted   (req_accepted),
      .want       (want[g])
    );
  end

  irq_lowest_pick #(.N(NPINS), .IDX_W(IDX_W)) u_pick (
    .want (want),
    .any  (req_valid),
    .idx  (req_pin)
  );
endmodule

// File: rtl/irq_pin_router_chk.sv
module irq_pin_router_chk #(
  parameter int NPINS = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [NPINS-1:0] pin_level,
  input logic [NPINS-1:0] polarity,
  input logic [NPINS-1:0] trig_level,
  input logic [NPINS-1:0] mask,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_accepted,
  input logic [IDX_W-1:0] req_pin
);
  logic [NPINS-1:0] eff_q;
  logic             rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) eff_q <= '0;
    else     eff_q <= pin_level ^ polarity;
  end

  always_comb begin
    if (rst) assert_reset_quiet_R1: assert (!req_valid);
  end

  assert_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> !req_valid);

  assert_masked_silent_R6: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !mask[req_pin]);

  assert_active_line_R3: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> eff_q[req_pin]);

  assert_rirr_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_accepted && trig_level[req_pin])
    |=> (!trig_level[$past(req_pin)] || !(req_valid && req_pin == $past(req_pin))));

  assert_edge_once_R5: assert property (@(posedge clk) disable iff (rst || rst_q)
    (req_valid && req_ready && !trig_level[req_pin]
     && $stable(pin_level) && $stable(polarity) && $stable(trig_level))
    |=> !(req_valid && req_pin == $past(req_pin)));
endmodule

bind irq_pin_router irq_pin_router_chk #(.NPINS(NPINS), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .pin_level    (pin_level),
  .polarity     (polarity),
  .trig_level   (trig_level),
  .mask         (mask),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_accepted (req_accepted),
  .req_pin      (req_pin)
);

// File: tb/tb_irq_pin_router.sv
module tb_irq_pin_router;
  localparam int NP = 8;
  localparam int VW = 8;
  localparam int IW = 3;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst;
  logic [NP-1:0] pin_level, polarity, trig_level, mask;
  logic [VW-1:0] vtab [NP];
  logic [NP*VW-1:0] vec_flat;
  logic          eoi_valid;
  logic [VW-1:0] eoi_vector;
  logic          req_valid, req_ready, req_accepted;
  logic [IW-1:0] req_pin;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  string tag = "R1";

  bit m_pend [NP];
  bit m_rirr [NP];
  bit m_prev [NP];

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < NP; i++) vec_flat[i*VW +: VW] = vtab[i];
  end

  irq_pin_router #(.NPINS(NP), .VEC_W(VW)) dut (
    .clk(clk), .rst(rst), .pin_level(pin_level), .polarity(polarity),
    .trig_level(trig_level), .mask(mask), .vec_flat(vec_flat),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .req_valid(req_valid),
    .req_ready(req_ready), .req_accepted(req_accepted), .req_pin(req_pin)
  );

  function automatic int model_pick();
    for (int i = 0; i < NP; i++)
      if (m_pend[i] && !mask[i] && (!trig_level[i] || !m_rirr[i])) return i;
    return -1;
  endfunction

  task automatic compare();
    int w;
    bit ev;
    w  = model_pick();
    ev = (w >= 0);
    n_cmp++;
    if (req_valid !== ev || (ev && req_pin !== IW'(w))) begin
      n_bad++;
      $display("FAIL %s: valid=%0b pin=%0d expected valid=%0b pin=%0d at %0t",
               tag, req_valid, req_pin, ev, w, $time);
    end
  endtask

  task automatic model_update();
    int  w;
    bit  hs, eff, srv;
    w  = model_pick();
    hs = (w >= 0) && req_ready;
    for (int i = 0; i < NP; i++) begin
      if (rst) begin
        m_pend[i] = 0; m_rirr[i] = 0; m_prev[i] = 0;
      end else begin
        eff = pin_level[i] ^ polarity[i];
        srv = hs && (w == i);
        if (trig_level[i]) m_pend[i] = eff;
        else if (eff && !m_prev[i]) m_pend[i] = 1;
        else if (!eff) m_pend[i] = 0;
        else if (srv || mask[i]) m_pend[i] = 0;
        if (srv && trig_level[i] && req_accepted) m_rirr[i] = 1;
        else if (eoi_valid && trig_level[i] && vtab[i] == eoi_vector) m_rirr[i] = 0;
        m_prev[i] = eff;
      end
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) begin
      #1 compare();
      @(posedge clk);
      model_update();
      @(negedge clk);
    end
  endtask

  task automatic eoi(input logic [VW-1:0] v);
    eoi_valid = 1; eoi_vector = v;
    cyc(1);
    eoi_valid = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    for (int i = 0; i < NP; i++) vtab[i] = VW'(8'h30 + i);
    vtab[7] = vtab[6];
    pin_level = '0; polarity = '0; trig_level = '0; mask = '1;
    eoi_valid = 0; eoi_vector = '0; req_ready = 0; req_accepted = 0;
    rst = 1;
    @(negedge clk);
    tag = "R1"; pin_level = 8'h0F; mask = '0;
    cyc(3);
    pin_level = '0; mask = '1; rst = 0;
    cyc(2);

    tag = "R2"; trig_level[2] = 1; mask[2] = 0; polarity[2] = 1;
    cyc(3);
    tag = "R9"; cyc(3);
    tag = "R3"; pin_level[2] = 1; cyc(3);
    polarity[2] = 0; pin_level[2] = 0; cyc(1);

    tag = "R4"; trig_level[1] = 1; mask[1] = 0; pin_level[1] = 1;
    req_ready = 1; req_accepted = 0; cyc(3);
    req_accepted = 1; cyc(4);

    tag = "R7"; eoi(8'hEE); cyc(2);
    eoi(vtab[1]); cyc(3);
    pin_level[1] = 0; cyc(1);
    eoi(vtab[1]); cyc(3);

    tag = "R5"; trig_level[3] = 0; mask[3] = 0; pin_level[3] = 1; cyc(4);
    pin_level[3] = 0; cyc(2);
    pin_level[3] = 1; cyc(3);

    tag = "R6"; req_ready = 0; mask[4] = 1; pin_level[4] = 1; cyc(3);
    mask[4] = 0; req_ready = 1; cyc(3);
    trig_level[5] = 1; mask[5] = 1; pin_level[5] = 1; cyc(3);
    tag = "R10"; mask[5] = 0; cyc(3);

    tag = "R8"; req_ready = 0;
    mask[0] = 0; mask[6] = 0; mask[7] = 0;
    pin_level[0] = 1; pin_level[6] = 1; pin_level[7] = 1; cyc(2);
    req_ready = 1; cyc(5);

    tag = "R7";
    trig_level[6] = 1; trig_level[7] = 1; req_accepted = 1; cyc(3);
    pin_level[6] = 1; pin_level[7] = 1; cyc(2);
    eoi(vtab[6]); cyc(3);

    tag = "R8";
    for (int c = 0; c < 3000; c++) begin
      pin_level    = pin_level ^ NP'($urandom & $urandom & $urandom);
      if ($urandom % 10 == 0) mask = mask ^ NP'($urandom & $urandom);
      if ($urandom % 25 == 0) trig_level = trig_level ^ NP'($urandom & $urandom);
      if ($urandom % 40 == 0) polarity = polarity ^ NP'($urandom & $urandom);
      req_ready    = ($urandom % 3) != 0;
      req_accepted = ($urandom % 4) != 0;
      eoi_valid    = ($urandom % 5) == 0;
      eoi_vector   = vtab[$urandom % NP];
      cyc(1);
    end
    eoi_valid = 0;
    cyc(2);
    summary();
  end
endmodule